// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in and returns a 16-bit sum with a carry-out. It has no clock and holds no state. The operands are split into four 4-bit groups. Each group forms per-bit generate and propagate terms, works out its internal carries as flat sum-of-products terms, and reports one group generate and one group propagate.

A second lookahead stage takes the four group generate/propagate pairs and the carry-in and forms the carries into the three upper groups. It uses the same equations as the stage inside each group. No carry ripples from one group to the next. The block also reports a 16-bit-wide generate and propagate pair, so that a wider adder can place another lookahead level above it.

Top module: `lookahead_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of the arithmetic value `a_i + b_i + cin_i`, taking both operands as unsigned.
- R2: `cout_o` equals bit 16 of the 17-bit value `a_i + b_i + cin_i`.
- R3: `grp_prop_o` is 1 exactly when `a_i` and `b_i` differ in every one of the 16 bit positions. Otherwise it is 0.
- R4: `grp_gen_o` is 1 exactly when `a_i + b_i`, with no carry-in, is 65536 or more.
- R5: `cout_o` equals `grp_gen_o OR (grp_prop_o AND cin_i)` for every input.
- R6: When the operands differ in every bit, the carry-in crosses all four groups. With `cin_i`=1 the sum is 0x0000 and `cout_o` is 1. With `cin_i`=0 the sum is 0xFFFF and `cout_o` is 0.
- R7: A carry made in any one group reaches the group above it. For example, 0x000F + 0x0001 gives 0x0010, 0x00FF + 0x0001 gives 0x0100, and 0xFFFF + 0x0001 gives 0x0000 with `cout_o`=1.
- R8: Adding zero changes nothing: `a_i` + 0 with `cin_i`=0 gives `sum_o`=`a_i`, `cout_o`=0 and `grp_gen_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First unsigned operand |
| b_i | input | 16 | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Generate over all 16 bits, for cascading |
| grp_prop_o | output | 1 | Propagate over all 16 bits, for cascading |

## Verification
Whenever an input changes, the bound checker compares the outputs with plain arithmetic. It covers the 17-bit sum, the exact conditions for the 16-bit generate and propagate outputs, and the rule that ties the carry-out to them. These checks cover R1 to R5 for any input. The specific carry paths in R6 to R8 can only be shown by the bench, which applies chosen vectors. These are carries that cross every group boundary, all-propagate operands, and a zero addend. The bench also sweeps every pairing of repeated nibble patterns and a set of random operands.

// File: rtl/lookahead_adder16.sv
module lookahead_adder16 (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        cin_i,
  output logic [15:0] sum_o,
  output logic        cout_o,
  output logic        grp_gen_o,
  output logic        grp_prop_o
);
  localparam int GW = 4;
  localparam int NG = 16 / GW;

  function automatic logic [2:0] la_carry(input logic [3:0] g, input logic [3:0] p, input logic c0);
    logic [2:0] c;
    c[0] = g[0] | (p[0] & c0);
    c[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    c[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
    return c;
  endfunction

  function automatic logic [1:0] la_group(input logic [3:0] g, input logic [3:0] p);
    logic gg, gp;
    gg = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
    gp = &p;
    return {gg, gp};
  endfunction

  logic [15:0]   bit_g, bit_p;
  logic [NG-1:0] blk_g, blk_p;
  logic [NG-1:0] blk_cin;
  logic [2:0]    up_c;
  logic [1:0]    top_gp;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  assign up_c    = la_carry(blk_g, blk_p, cin_i);
  assign blk_cin = {up_c, cin_i};
  assign top_gp  = la_group(blk_g, blk_p);

  for (genvar k = 0; k < NG; k++) begin : g_blk
    localparam int L = k * GW;
    logic [2:0] in_c;
    assign in_c = la_carry(bit_g[L +: GW], bit_p[L +: GW], blk_cin[k]);
    assign sum_o[L +: GW] = bit_p[L +: GW] ^ {in_c, blk_cin[k]};
    assign {blk_g[k], blk_p[k]} = la_group(bit_g[L +: GW], bit_p[L +: GW]);
  end

  assign grp_gen_o  = top_gp[1];
  assign grp_prop_o = top_gp[0];
  assign cout_o     = grp_gen_o | (grp_prop_o & cin_i);
endmodule

// File: rtl/lookahead_adder16_chk.sv
module lookahead_adder16_chk (
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic        cin_i,
  input logic [15:0] sum_o,
  input logic        cout_o,
  input logic        grp_gen_o,
  input logic        grp_prop_o
);
  logic [16:0] ref_full, ref_nocin;
  assign ref_full  = {1'b0, a_i} + {1'b0, b_i} + {16'd0, cin_i};
  assign ref_nocin = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    p_sum_r1:  assert (sum_o == ref_full[15:0]) else $error("R1 sum mismatch");
    p_cout_r2: assert (cout_o == ref_full[16]) else $error("R2 carry-out mismatch");
    p_prop_r3: assert (grp_prop_o == (a_i == ~b_i)) else $error("R3 propagate mismatch");
    p_gen_r4:  assert (grp_gen_o == ref_nocin[16]) else $error("R4 generate mismatch");
    p_cas_r5:  assert (cout_o == (grp_gen_o | (grp_prop_o & cin_i))) else $error("R5 cascade mismatch");
  end
endmodule

bind lookahead_adder16 lookahead_adder16_chk u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o),
  .cout_o(cout_o), .grp_gen_o(grp_gen_o), .grp_prop_o(grp_prop_o)
);

// File: tb/sim_lookahead_adder16.sv
module sim_lookahead_adder16;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] a, b, sum;
  logic cin, cout, gen, prop;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  lookahead_adder16 u0 (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum),
                        .cout_o(cout), .grp_gen_o(gen), .grp_prop_o(prop));

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
    end
  endtask

  task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc);
    logic [16:0] full, nocin;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    @(posedge clk); #1;
    full  = {1'b0, va} + {1'b0, vb} + {16'd0, vc};
    nocin = {1'b0, va} + {1'b0, vb};
    chk("R1", {1'b0, sum}, {1'b0, full[15:0]});
    chk("R2", {16'd0, cout}, {16'd0, full[16]});
    chk("R3", {16'd0, prop}, {16'd0, (va ^ vb) == 16'hFFFF});
    chk("R4", {16'd0, gen}, {16'd0, nocin[16]});
    chk("R5", {16'd0, cout}, {16'd0, gen | (prop & vc)});
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    @(posedge clk); #1;
    chk("R1 idle", {1'b0, sum}, 17'd0);
    chk("R2 idle", {16'd0, cout}, 17'd0);

    // R6: all-propagate operands
    apply(16'hA5A5, 16'h5A5A, 1'b1);
    chk("R6 sum", {1'b0, sum}, 17'd0);
    chk("R6 cout", {16'd0, cout}, 17'd1);
    apply(16'h0F0F, 16'hF0F0, 1'b0);
    chk("R6 sum", {1'b0, sum}, {1'b0, 16'hFFFF});
    chk("R6 cout", {16'd0, cout}, 17'd0);

    // R7: carries crossing each group boundary
    apply(16'h000F, 16'h0001, 1'b0);
    chk("R7 g0", {1'b0, sum}, {1'b0, 16'h0010});
    apply(16'h00FF, 16'h0001, 1'b0);
    chk("R7 g1", {1'b0, sum}, {1'b0, 16'h0100});
    apply(16'h0FFF, 16'h0000, 1'b1);
    chk("R7 g2", {1'b0, sum}, {1'b0, 16'h1000});
    apply(16'hFFFF, 16'h0001, 1'b0);
    chk("R7 top", {cout, sum}, 17'h10000);
    apply(16'hAAAA, 16'h5555, 1'b0);
    apply(16'h5555, 16'h5555, 1'b1);

    // R8: zero addend
    apply(16'h1234, 16'h0000, 1'b0);
    chk("R8 sum", {1'b0, sum}, {1'b0, 16'h1234});
    chk("R8 gen", {16'd0, gen}, 17'd0);
    apply(16'hFFFF, 16'h0000, 1'b0);
    chk("R8 cout", {16'd0, cout}, 17'd0);
    apply(16'h0000, 16'h0000, 1'b0);

    // repeated-nibble sweep
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++)
          apply({4{x[3:0]}}, {4{y[3:0]}}, c[0]);

    // random operands
    for (int i = 0; i < 1500; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule